// File: doc/BRIEF.md
# Gap-Skipping Iteration Sequencer

This block steps through the pole orders that a decoder over a field of size q² has to visit, with q a power of two. Some integers cannot be written as a·q + b·(q+1) with a ≥ 0 and 0 ≤ b < q. These are the gaps, and the decoder has no work to do for them. The sequencer never spends a cycle on a gap. Each advance moves it straight to the next representable value, even when a whole run of gaps lies in between.

A gap is found from the value alone. Its upper bits (the quotient by q) are compared with its low log2(q) bits (the remainder). The value is a gap exactly when the quotient is strictly smaller than the remainder. If the value just after the current index is a gap, the sequencer rounds it up to the next multiple of q, which is never a gap. The same detector is also wired to a standalone query port, so surrounding control logic can classify any value it needs to.

A pulse on start loads index 0. Each advance then issues the next non-gap. When that next non-gap would exceed the limit m, the block stops and raises done.

Top module: `gap_skip_seq`

## Requirements
- R1: While reset is applied, and after it is released, idx_valid and done are 0 and idx is 0.
- R2: query_gap is 1 exactly when query_s has no representation a·q + b·(q+1) with integers a ≥ 0 and 0 ≤ b < q. It is combinational, with no clock delay. For q = 16 there are 120 gaps, and every value of 240 or more is a non-gap.
- R3: One cycle after a cycle with start = 1, idx is 0, idx_valid is 1 and done is 0. This holds in any state, and start takes priority over advance.
- R4: When idx_valid is 1 and advance is 1 in a cycle, the next cycle shows the smallest non-gap that is strictly greater than the current idx, provided that value is ≤ limit_m. A run of gaps costs no extra cycle.
- R5: Whenever idx_valid is 1, idx is a non-gap.
- R6: When idx_valid is 1, advance is 1, and the next non-gap is greater than limit_m, the next cycle has done = 1 and idx_valid = 0. done then stays 1 until the next start.
- R7: advance has no effect while idx_valid is 0, that is before the first start or after done. idx, idx_valid and done keep their values.
- R8: While idx_valid is 1 and advance and start are 0, idx and idx_valid hold.
- R9: Between a start and done, the values issued are exactly the non-gaps from 0 to limit_m, in increasing order, each issued once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Begin a new sequence at index 0 |
| advance | input | 1 | Request the next non-gap index |
| limit_m | input | IW | Largest index that may be issued; held stable during a run |
| query_s | input | IW | Value to classify |
| query_gap | output | 1 | 1 when query_s is a gap |
| idx | output | IW | Current iteration index |
| idx_valid | output | 1 | idx holds an issued index |
| done | output | 1 | Sequence has passed limit_m |

## Verification
A wrong skip step shows up at idx one cycle after the advance that caused it. idx then either lands on a gap or jumps over a non-gap, and a count of issued values against the brute-force count of non-gaps up to m catches any omission by the end of the run. A corrupted state register shows up at once, either as done and idx_valid disagreeing or as advance changing idx when it should be ignored. A wrong comparison in the detector appears directly on query_gap, and an exhaustive sweep of every value below 2q² exposes it.

// File: rtl/gap_skip_pkg.sv
package gap_skip_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/gap_detect.sv
// Classifies s as a gap: quotient by q strictly below remainder mod q.
module gap_detect #(
  parameter int W     = 12,
  parameter int LOG2Q = 4
) (
  input  logic [W-1:0] s,
  output logic         gap
);
  localparam int Q  = 1 << LOG2Q;
  localparam int HW = W - LOG2Q;
  localparam logic [W:0] NONGAP_FLOOR = (W+1)'(Q*Q - Q);

  logic [HW-1:0]    quo;
  logic [LOG2Q-1:0] rem;

  assign quo = s[W-1:LOG2Q];
  assign rem = s[LOG2Q-1:0];
  assign gap = quo < HW'(rem);

  always_comb begin
    if ({1'b0, s} >= NONGAP_FLOOR) begin
      AST_HIGH_NONGAP: assert (!gap); // R2
    end
  end
endmodule

// File: rtl/next_nongap.sv
// From the current index, the smallest non-gap above it (one extra bit for overflow).
module next_nongap #(
  parameter int IW    = 12,
  parameter int LOG2Q = 4
) (
  input  logic [IW-1:0] cur,
  output logic [IW:0]   nxt
);
  localparam int HW = IW + 1 - LOG2Q;

  logic [IW:0]   cand;
  logic          cand_gap;
  logic [HW-1:0] hi_inc;
  logic [IW:0]   rounded;

  assign cand = {1'b0, cur} + (IW+1)'(1);

  gap_detect #(.W(IW+1), .LOG2Q(LOG2Q)) u_cand_gap (
    .s   (cand),
    .gap (cand_gap)
  );

  assign hi_inc  = cand[IW:LOG2Q] + HW'(1);
  assign rounded = {hi_inc, {LOG2Q{1'b0}}};
  assign nxt     = cand_gap ? rounded : cand;

  always_comb begin
    AST_STRICT_INC: assert (nxt > {1'b0, cur}); // R4
  end
endmodule

// File: rtl/gap_skip_seq.sv
module gap_skip_seq
  import gap_skip_pkg::*;
#(
  parameter int IW    = 12,
  parameter int LOG2Q = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          advance,
  input  logic [IW-1:0] limit_m,
  input  logic [IW-1:0] query_s,
  output logic          query_gap,
  output logic [IW-1:0] idx,
  output logic          idx_valid,
  output logic          done
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Standalone query detector.
  gap_detect #(.W(IW), .LOG2Q(LOG2Q)) u_query_gap (
    .s   (query_s),
    .gap (query_gap)
  );

  // Skip calculator.
  logic [IW:0] nxt_idx;

  next_nongap #(.IW(IW), .LOG2Q(LOG2Q)) u_next (
    .cur (idx_q),
    .nxt (nxt_idx)
  );

  seq_state_t    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en, state_en;
  logic          past_limit;

  assign past_limit = nxt_idx > {1'b0, limit_m};

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (start) begin
      state_d = SEQ_RUN;
      idx_d   = '0;
    end else if (state_q == SEQ_RUN && advance) begin
      if (past_limit) state_d = SEQ_FIN;
      else            idx_d   = nxt_idx[IW-1:0];
    end
  end

  assign idx_en   = start || (state_q == SEQ_RUN && advance && !past_limit);
  assign state_en = start || (state_q == SEQ_RUN && advance && past_limit);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (idx_en)   idx_q   <= idx_d;
    end
  end

  assign idx       = idx_q;
  assign idx_valid = (state_q == SEQ_RUN);
  assign done      = (state_q == SEQ_FIN);

  // Independent classification of the issued index.
  logic idx_gap;
  gap_detect #(.W(IW), .LOG2Q(LOG2Q)) u_idx_gap (
    .s   (idx_q),
    .gap (idx_gap)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_core_n |-> (!idx_valid && !done)); // R1
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    start |=> (idx == '0 && idx_valid && !done)); // R3
  AST_ADV_UP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idx_valid && advance && !start) |=> (done || idx > $past(idx))); // R4
  AST_IDX_NONGAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    idx_valid |-> !idx_gap); // R5
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> !idx_valid); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done && !start) |=> done); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!idx_valid && !start) |=> ($stable(idx) && !idx_valid)); // R7
  AST_NOADV_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idx_valid && !advance && !start) |=> ($stable(idx) && idx_valid)); // R8
endmodule

// File: tb/gap_skip_seq_tb.sv
module gap_skip_seq_tb;
  localparam int IW    = 12;
  localparam int LOG2Q = 4;
  localparam int Q     = 1 << LOG2Q;
  localparam int IMAX  = (1 << IW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, advance;
  logic [IW-1:0] limit_m, query_s;
  logic          query_gap;
  logic [IW-1:0] idx;
  logic          idx_valid, done;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gap_skip_seq #(.IW(IW), .LOG2Q(LOG2Q)) u_dut (
    .clk, .rst_n, .start, .advance, .limit_m, .query_s,
    .query_gap, .idx, .idx_valid, .done
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic bit ref_gap(int s);
    for (int a = 0; a * Q <= s; a++)
      for (int b = 0; b < Q; b++)
        if (a * Q + b * (Q + 1) == s) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int ref_next(int cur);
    int n = cur + 1;
    while (ref_gap(n)) n++;
    return n;
  endfunction

  function automatic int ref_count(int m);
    int c = 0;
    for (int s = 0; s <= m; s++) if (!ref_gap(s)) c++;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_seq(int m);
    int exp_idx, nx, issued;
    bit adv;
    limit_m = IW'(m);
    start = 1'b1; tick(); start = 1'b0;
    chk(idx_valid && !done && int'(idx) == 0, "R3 start", int'(idx), 0);
    exp_idx = 0; issued = 1;
    forever begin
      adv = ($urandom % 4) != 0;
      advance = adv; tick(); advance = 1'b0;
      if (!adv) begin
        chk(idx_valid && int'(idx) == exp_idx, "R8 hold", int'(idx), exp_idx);
        continue;
      end
      nx = ref_next(exp_idx);
      if (nx > m) begin
        chk(done && !idx_valid, "R6 done", {30'd0, done, idx_valid}, 2);
        break;
      end
      chk(idx_valid && int'(idx) == nx, "R4 R5 next", int'(idx), nx);
      exp_idx = nx; issued++;
    end
    chk(issued == ref_count(m), "R9 count", issued, ref_count(m));
    advance = 1'b1; tick(); advance = 1'b0; tick();
    chk(done && !idx_valid && int'(idx) == exp_idx, "R7 R6 after done", int'(idx), exp_idx);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; advance = 1'b0; limit_m = '0; query_s = '0;
    tick(); tick();
    chk(!idx_valid && !done && idx == '0, "R1 in reset", int'(idx), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk(!idx_valid && !done && idx == '0, "R1 after reset", int'(idx), 0);

    // R7: advance before any start
    advance = 1'b1; tick(); tick(); advance = 1'b0;
    chk(!idx_valid && !done && idx == '0, "R7 idle advance", int'(idx), 0);

    // R2: exhaustive sweep below 2q^2
    begin
      int gaps = 0;
      for (int s = 0; s < 2 * Q * Q; s++) begin
        query_s = IW'(s); #1;
        chk(query_gap == ref_gap(s), "R2 query", int'(query_gap), int'(ref_gap(s)));
        if (query_gap) gaps++;
      end
      chk(gaps == Q * (Q - 1) / 2, "R2 gap total", gaps, Q * (Q - 1) / 2);
      for (int k = 0; k < 50; k++) begin
        int s = int'($urandom % (IMAX + 1));
        query_s = IW'(s); #1;
        chk(query_gap == ref_gap(s), "R2 random query", int'(query_gap), int'(ref_gap(s)));
      end
    end

    // Directed limits around gap runs and the top of the range
    run_seq(0);
    run_seq(1);
    run_seq(Q - 1);
    run_seq(Q);
    run_seq(Q + 1);
    run_seq(Q * Q - Q - 1);
    run_seq(Q * Q - Q);
    run_seq(2 * Q * Q - 1);
    run_seq(IMAX);
    for (int k = 0; k < 12; k++) run_seq(int'($urandom % 1024));

    // R3: start overrides advance mid-run
    limit_m = IW'(300);
    start = 1'b1; tick(); start = 1'b0;
    for (int k = 0; k < 5; k++) begin advance = 1'b1; tick(); end
    start = 1'b1; advance = 1'b1; tick(); start = 1'b0; advance = 1'b0;
    chk(idx_valid && !done && idx == '0, "R3 restart", int'(idx), 0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk(int'(idx) == Q, "R4 after restart", int'(idx), Q);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule